// File: doc/BRIEF.md
# Serial Control Slave with Register Bank and Packet Ports

This block is the control-port slave of a video graphics decoder. An external host drives a chip-enable line, a bit clock and a data line. The host reads back through a data-out pin that is released whenever the slave is not talking. While chip-enable is high, the slave samples the data line on each rising edge of the bit clock, least significant bit first. The first byte of each frame is a command address. One address opens a write frame. That frame carries register writes, or one packet write that is handed on when chip-enable falls. The other address opens a readout frame. It returns a status byte, then a packet of data bytes that the rest of the chip supplies. The host may stop after any whole byte.

All three host pins are synchronised into the system clock domain before use. The control registers are presented in parallel to the rest of the chip. Register 1 is also decoded into two signed position offsets. Bit 7 of register 0 triggers an internal re-initialisation that clears itself.

A written packet leaves on a valid/ready port. `pkt_valid_o` rises once a packet frame completes. It stays high, with `pkt_data_o` frozen, until a cycle in which `pkt_ready_i` is high. The slave has no buffer for a second packet, so a packet frame that overlaps a pending one is dropped.

Top module: `serctl_slave`

## Requirements
- R1: After reset, register 2 and register 3 hold FFh and every other register holds 00h. `do_oe_o`, `pkt_valid_o` and `init_o` are low, and `do_o` is 1.
- R2: While `ce_i` is high, bits are taken from `di_i` on rising edges of `cl_i`, least significant bit first. The first byte of a frame is the address: F4h opens a write frame, F5h opens a readout frame, and any other value makes the rest of the frame ignored. Each rising edge of `ce_i` starts a new frame.
- R3: In a write frame, a control byte with bit 7 = 0 names a register in bits 3:0. The next byte is written to that register. Several control/data pairs may follow one another in one frame. Register i appears on `regs_o[8i+7:8i]`.
- R4: A write to a register number at or above NUM_REGS (default 14) changes no register.
- R5: Register 1 bits 3:0 (horizontal) and bits 7:4 (vertical) are 4-bit two's-complement steps. `h_off_o` and `v_off_o` give each step times two as a 6-bit signed value, covering -16 to +14.
- R6: Writing register 0 with bit 7 set raises `init_o` for exactly one cycle. In the following cycle every register, including register 0, returns to its reset value.
- R7: In a write frame, a control byte with bit 7 = 1 starts a packet. Exactly PKT_BYTES (default 18) further bytes must follow. When `ce_i` falls, `pkt_valid_o` rises and packet byte k appears on `pkt_data_o[8k+7:8k]`. A packet frame with any other byte count is discarded.
- R8: `pkt_valid_o` stays high with `pkt_data_o` unchanged until a cycle in which `pkt_ready_i` is high. A packet frame is dropped if any of its bytes completes while `pkt_valid_o` is high, or if `pkt_valid_o` is high when its `ce_i` falls.
- R9: In a readout frame, `do_oe_o` rises after the address byte and `do_o` presents the status byte, then the `rd_data_i` bytes, byte 0 first. Each byte is sent LSB first, and a new bit is presented after each `cl_i` rising edge. Status bit 0 is first-valid, bit 1 is wait (1 = idle), bit 2 is vertical blanking and bit 3 is disc type. Bits 5:4 are the Q flags and bits 7:6 are the P flags. After the last data byte `do_o` reads 1.
- R10: The host may drop `ce_i` after any whole byte of a readout. `do_oe_o` then falls, and the next frame is decoded from its address byte.
- R11: Outside a readout frame with `ce_i` high, `do_oe_o` is low and `do_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_i | input | 1 | Host chip enable, active high |
| cl_i | input | 1 | Host bit clock |
| di_i | input | 1 | Host serial data in |
| do_o | output | 1 | Serial data out (1 when released) |
| do_oe_o | output | 1 | Data-out drive enable (open-drain control) |
| regs_o | output | NUM_REGS*8 | Parallel view of all registers |
| init_o | output | 1 | One-cycle internal re-initialisation pulse |
| h_off_o | output | 6 | Signed horizontal offset from register 1 |
| v_off_o | output | 6 | Signed vertical offset from register 1 |
| pkt_valid_o | output | 1 | Written packet available |
| pkt_ready_i | input | 1 | Consumer accepts the packet |
| pkt_data_o | output | PKT_BYTES*8 | Written packet bytes |
| st_first_i | input | 1 | Status: first-valid flag |
| st_wait_i | input | 1 | Status: wait flag (1 = idle) |
| st_vblank_i | input | 1 | Status: vertical blanking |
| st_disc_i | input | 1 | Status: disc type (1 = graphics disc) |
| st_qflag_i | input | 2 | Status: Q correction flags |
| st_pflag_i | input | 2 | Status: P correction flags |
| rd_data_i | input | PKT_BYTES*8 | Bytes returned by a readout |

## Verification
The hardest case to reach is the one where a second packet frame overlaps a first packet that is still waiting. To get there, the bench holds `pkt_ready_i` low after a complete packet and streams a whole new packet frame with different bytes. It then checks three things: the first packet's data is still on the port, releasing it leaves nothing valid, and no late packet appears afterwards. A readout aborted after its status byte alone is followed directly by a register write frame. This shows that the early end left no state behind.

// File: rtl/serctl_pkg.sv
package serctl_pkg;
  typedef enum logic [2:0] {
    FR_ADDR,
    FR_CTRL,
    FR_DATA,
    FR_PKT,
    FR_READ,
    FR_SKIP
  } frame_e;

  localparam logic [7:0] CMD_WRITE = 8'hF4;
  localparam logic [7:0] CMD_READ  = 8'hF5;

  function automatic logic [7:0] reg_default(input int idx);
    return (idx == 2 || idx == 3) ? 8'hFF : 8'h00;
  endfunction
endpackage

// File: rtl/serctl_sync.sv
module serctl_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
    end else begin
      pipe[0] <= d_in;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q_out = pipe[STAGES-1];
endmodule

// File: rtl/serctl_regfile.sv
module serctl_regfile
  import serctl_pkg::*;
#(
  parameter int NUM_REGS = 14,
  parameter int AW       = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_idx,
  input  logic [7:0]            wr_byte,
  output logic [NUM_REGS*8-1:0] regs_o,
  output logic                  init_o
);
  // Register 0 bit 7 is the self-clearing re-initialisation request.
  assign init_o = regs_o[7];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs_o[8*g +: 8] <= reg_default(g);
      else if (init_o)
        regs_o[8*g +: 8] <= reg_default(g);
      else if (wr_en && wr_idx == AW'(g))
        regs_o[8*g +: 8] <= wr_byte;
    end
  end

  // R4
  unimpl_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_idx) >= NUM_REGS && !init_o) |=> $stable(regs_o));

  // R6
  init_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_o |=> (!init_o && regs_o[7:0] == 8'h00));
endmodule

// File: rtl/serctl_tx.sv
module serctl_tx #(
  parameter int NBYTES = 18
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                step,
  input  logic [7:0]          flags_i,
  input  logic [NBYTES*8-1:0] data_i,
  output logic                bit_o
);
  localparam int BW = $clog2(NBYTES + 2);

  logic [7:0]    sh;
  logic [2:0]    bit_i;
  logic [BW-1:0] byte_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= 8'hFF;
      bit_i  <= '0;
      byte_i <= '0;
    end else if (load) begin
      sh     <= flags_i;
      bit_i  <= '0;
      byte_i <= '0;
    end else if (step) begin
      bit_i <= bit_i + 3'd1;
      if (bit_i == 3'd7) begin
        if (byte_i < BW'(NBYTES)) begin
          sh     <= data_i[8*int'(byte_i) +: 8];
          byte_i <= byte_i + 1'b1;
        end else begin
          sh <= 8'hFF;
        end
      end else begin
        sh <= {1'b1, sh[7:1]};
      end
    end
  end

  assign bit_o = sh[0];

  // R9
  flag_first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (bit_o == $past(flags_i[0])));
endmodule

// File: rtl/serctl_slave.sv
module serctl_slave
  import serctl_pkg::*;
#(
  parameter int NUM_REGS    = 14,
  parameter int PKT_BYTES   = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ce_i,
  input  logic                   cl_i,
  input  logic                   di_i,
  output logic                   do_o,
  output logic                   do_oe_o,
  output logic [NUM_REGS*8-1:0]  regs_o,
  output logic                   init_o,
  output logic [5:0]             h_off_o,
  output logic [5:0]             v_off_o,
  output logic                   pkt_valid_o,
  input  logic                   pkt_ready_i,
  output logic [PKT_BYTES*8-1:0] pkt_data_o,
  input  logic                   st_first_i,
  input  logic                   st_wait_i,
  input  logic                   st_vblank_i,
  input  logic                   st_disc_i,
  input  logic [1:0]             st_qflag_i,
  input  logic [1:0]             st_pflag_i,
  input  logic [PKT_BYTES*8-1:0] rd_data_i
);
  localparam int PCW = $clog2(PKT_BYTES + 2);
  localparam int AW  = 4;

  // Synchronised host pins and edge detection
  logic [2:0] pins_s;
  logic       ce_s, cl_s, di_s, ce_d, cl_d;
  logic       cl_rise, ce_fall;

  serctl_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({ce_i, cl_i, di_i}),
    .q_out (pins_s)
  );
  assign {ce_s, cl_s, di_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_d <= 1'b0;
      cl_d <= 1'b0;
    end else begin
      ce_d <= ce_s;
      cl_d <= cl_s;
    end
  end

  assign cl_rise = cl_s && !cl_d && ce_s;
  assign ce_fall = ce_d && !ce_s;

  // Byte assembly, LSB first
  logic [7:0] shreg;
  logic [2:0] bitcnt;
  logic [7:0] rx_byte;
  logic       byte_done;

  assign rx_byte   = {di_s, shreg[7:1]};
  assign byte_done = cl_rise && (bitcnt == 3'd7);

  // Frame decoder
  frame_e          mode;
  logic [AW-1:0]   reg_sel;
  logic [PCW-1:0]  pkt_cnt;
  logic            pkt_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= FR_ADDR;
      shreg   <= '0;
      bitcnt  <= '0;
      reg_sel <= '0;
      pkt_cnt <= '0;
      pkt_ok  <= 1'b0;
    end else if (!ce_s) begin
      mode   <= FR_ADDR;
      bitcnt <= '0;
    end else if (cl_rise) begin
      shreg  <= rx_byte;
      bitcnt <= bitcnt + 3'd1;
      if (byte_done) begin
        unique case (mode)
          FR_ADDR: begin
            if (rx_byte == CMD_WRITE)     mode <= FR_CTRL;
            else if (rx_byte == CMD_READ) mode <= FR_READ;
            else                          mode <= FR_SKIP;
          end
          FR_CTRL: begin
            if (rx_byte[7]) begin
              mode    <= FR_PKT;
              pkt_cnt <= '0;
              pkt_ok  <= 1'b1;
            end else begin
              mode    <= FR_DATA;
              reg_sel <= rx_byte[AW-1:0];
            end
          end
          FR_DATA: mode <= FR_CTRL;
          FR_PKT: begin
            if (pkt_valid_o) pkt_ok <= 1'b0;
            if (pkt_cnt <= PCW'(PKT_BYTES)) pkt_cnt <= pkt_cnt + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // Register bank
  logic wr_en;
  assign wr_en = byte_done && (mode == FR_DATA);

  serctl_regfile #(.NUM_REGS(NUM_REGS), .AW(AW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (reg_sel),
    .wr_byte (rx_byte),
    .regs_o  (regs_o),
    .init_o  (init_o)
  );

  assign h_off_o = {regs_o[11], regs_o[11:8], 1'b0};
  assign v_off_o = {regs_o[15], regs_o[15:12], 1'b0};

  // Packet write path with valid/ready hand-off
  logic pkt_exec;
  assign pkt_exec = ce_fall && (mode == FR_PKT) && (pkt_cnt == PCW'(PKT_BYTES))
                    && pkt_ok && !pkt_valid_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt_data_o  <= '0;
      pkt_valid_o <= 1'b0;
    end else begin
      if (byte_done && mode == FR_PKT && !pkt_valid_o && pkt_cnt < PCW'(PKT_BYTES))
        pkt_data_o[8*int'(pkt_cnt) +: 8] <= rx_byte;
      if (pkt_exec)
        pkt_valid_o <= 1'b1;
      else if (pkt_ready_i)
        pkt_valid_o <= 1'b0;
    end
  end

  // Readout path
  logic       tx_load, tx_step, tx_bit;
  logic [7:0] flag_byte;

  assign flag_byte = {st_pflag_i, st_qflag_i, st_disc_i, st_vblank_i, st_wait_i, st_first_i};
  assign tx_load   = byte_done && (mode == FR_ADDR) && (rx_byte == CMD_READ);
  assign tx_step   = cl_rise && (mode == FR_READ);

  serctl_tx #(.NBYTES(PKT_BYTES)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tx_load),
    .step    (tx_step),
    .flags_i (flag_byte),
    .data_i  (rd_data_i),
    .bit_o   (tx_bit)
  );

  assign do_oe_o = ce_s && (mode == FR_READ);
  assign do_o    = do_oe_o ? tx_bit : 1'b1;

  // R11
  oe_after_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(do_oe_o) |-> $past(cl_rise));

  // R10
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ce_s) |-> !do_oe_o);

  // R8
  pkt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid_o && !pkt_ready_i) |=> (pkt_valid_o && $stable(pkt_data_o)));

  // R7
  pkt_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pkt_valid_o) |-> $past(pkt_cnt == PCW'(PKT_BYTES)));
endmodule

// File: tb/tb_serctl_slave.sv
module tb_serctl_slave;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_REGS   = 14;
  localparam int PKT_BYTES  = 18;

  logic clk = 0;
  logic rst_n = 0;
  logic ce = 0, cl = 0, di = 0;
  logic do_bit, do_oe;
  logic [NUM_REGS*8-1:0] regs;
  logic init_p;
  logic [5:0] h_off, v_off;
  logic pkt_valid;
  logic pkt_ready = 0;
  logic [PKT_BYTES*8-1:0] pkt_data;
  logic st_first = 0, st_wait = 0, st_vblank = 0, st_disc = 0;
  logic [1:0] st_q = 0, st_p = 0;
  logic [PKT_BYTES*8-1:0] rd_data = '0;

  int checks = 0;
  int errors = 0;
  int init_count = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (init_p) init_count++;

  serctl_slave #(.NUM_REGS(NUM_REGS), .PKT_BYTES(PKT_BYTES)) dut (
    .clk(clk), .rst_n(rst_n), .ce_i(ce), .cl_i(cl), .di_i(di),
    .do_o(do_bit), .do_oe_o(do_oe), .regs_o(regs), .init_o(init_p),
    .h_off_o(h_off), .v_off_o(v_off),
    .pkt_valid_o(pkt_valid), .pkt_ready_i(pkt_ready), .pkt_data_o(pkt_data),
    .st_first_i(st_first), .st_wait_i(st_wait), .st_vblank_i(st_vblank),
    .st_disc_i(st_disc), .st_qflag_i(st_q), .st_pflag_i(st_p), .rd_data_i(rd_data)
  );

  task automatic chk(input string tag, input logic [143:0] act, input logic [143:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    di = b;
    wait_clk(3);
    cl = 1;
    wait_clk(6);
    cl = 0;
    wait_clk(3);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) send_bit(b[i]);
  endtask

  task automatic read_byte(output logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      b[i] = do_bit;
      send_bit(1'b0);
    end
  endtask

  task automatic frame_begin(input logic [7:0] addr);
    ce = 1;
    wait_clk(4);
    send_byte(addr);
  endtask

  task automatic frame_end();
    ce = 0;
    wait_clk(8);
  endtask

  task automatic write_reg(input logic [7:0] idx, input logic [7:0] val);
    frame_begin(8'hF4);
    send_byte(idx);
    send_byte(val);
    frame_end();
  endtask

  function automatic logic [7:0] rg(input int i);
    return regs[8*i +: 8];
  endfunction

  function automatic logic [143:0] make_pkt(input int seed);
    logic [143:0] v;
    for (int k = 0; k < PKT_BYTES; k++) v[8*k +: 8] = 8'(k * 7 + seed);
    return v;
  endfunction

  task automatic send_packet(input logic [143:0] p, input int nbytes);
    frame_begin(8'hF4);
    send_byte(8'h80);
    for (int k = 0; k < nbytes; k++) send_byte(p[8*k +: 8]);
    frame_end();
  endtask

  task automatic t_reset();
    chk("R1 reg0", rg(0), 8'h00);
    chk("R1 reg2", rg(2), 8'hFF);
    chk("R1 reg3", rg(3), 8'hFF);
    chk("R1 reg13", rg(13), 8'h00);
    chk("R1 oe/do/valid/init", {do_oe, do_bit, pkt_valid, init_p}, 4'b0100);
  endtask

  task automatic t_regwrite();
    frame_begin(8'hF4);
    chk("R11 oe low in write frame", do_oe, 1'b0);
    send_byte(8'h05); send_byte(8'hA5);
    send_byte(8'h09); send_byte(8'h3C);
    frame_end();
    chk("R3 reg5", rg(5), 8'hA5);
    chk("R3 reg9 second pair", rg(9), 8'h3C);
    chk("R2 R11 do idle", {do_oe, do_bit}, 2'b01);
  endtask

  task automatic t_unimpl();
    logic [NUM_REGS*8-1:0] snap;
    snap = regs;
    frame_begin(8'hF4);
    send_byte(8'h0E); send_byte(8'h77);
    send_byte(8'h0F); send_byte(8'h66);
    frame_end();
    chk("R4 unimplemented writes", regs, snap);
  endtask

  task automatic t_badaddr();
    frame_begin(8'h12);
    send_byte(8'h03); send_byte(8'h55);
    frame_end();
    chk("R2 bad address ignored", rg(3), 8'hFF);
  endtask

  task automatic t_offset();
    write_reg(8'h01, 8'h8F);
    chk("R5 h=-2", h_off, 6'b111110);
    chk("R5 v=-16", v_off, 6'b110000);
    write_reg(8'h01, 8'h07);
    chk("R5 h=+14", h_off, 6'b001110);
    chk("R5 v=0", v_off, 6'b000000);
  endtask

  task automatic t_init();
    init_count = 0;
    write_reg(8'h00, 8'h81);
    chk("R6 one init pulse", 8'(init_count), 8'd1);
    chk("R6 reg0 default", rg(0), 8'h00);
    chk("R6 reg5 default", rg(5), 8'h00);
    chk("R6 reg2 default", rg(2), 8'hFF);
    chk("R6 reg1 default", rg(1), 8'h00);
  endtask

  task automatic t_packet();
    logic [143:0] p1, p2;
    p1 = make_pkt(3);
    p2 = make_pkt(100);
    send_packet(p1, PKT_BYTES);
    chk("R7 valid after packet", pkt_valid, 1'b1);
    chk("R7 packet data", pkt_data, p1);
    send_packet(p2, PKT_BYTES);
    chk("R8 held under back-pressure", {pkt_valid, pkt_data}, {1'b1, p1});
    pkt_ready = 1;
    wait_clk(1);
    pkt_ready = 0;
    wait_clk(4);
    chk("R8 overlapping packet dropped", pkt_valid, 1'b0);
    send_packet(p2, PKT_BYTES - 1);
    chk("R7 short packet discarded", pkt_valid, 1'b0);
    send_packet(p2, PKT_BYTES + 1);
    chk("R7 long packet discarded", pkt_valid, 1'b0);
    send_packet(p2, PKT_BYTES);
    chk("R7 second packet data", {pkt_valid, pkt_data}, {1'b1, p2});
    pkt_ready = 1;
    wait_clk(1);
    pkt_ready = 0;
    wait_clk(2);
  endtask

  task automatic t_readout();
    logic [7:0] b;
    logic [143:0] got;
    st_first = 1; st_wait = 0; st_vblank = 1; st_disc = 1;
    st_q = 2'b10; st_p = 2'b01;
    rd_data = make_pkt(41);
    frame_begin(8'hF5);
    chk("R9 oe high", do_oe, 1'b1);
    read_byte(b);
    chk("R9 flag byte", b, 8'h6D);
    for (int k = 0; k < PKT_BYTES; k++) begin
      read_byte(b);
      got[8*k +: 8] = b;
    end
    chk("R9 data bytes", got, rd_data);
    read_byte(b);
    chk("R9 after last byte", b, 8'hFF);
    frame_end();
    chk("R10 oe released", {do_oe, do_bit}, 2'b01);
  endtask

  task automatic t_abort();
    logic [7:0] b;
    st_first = 0; st_wait = 1; st_vblank = 0; st_disc = 0;
    st_q = 2'b01; st_p = 2'b10;
    frame_begin(8'hF5);
    read_byte(b);
    chk("R9 flag byte two", b, 8'h92);
    frame_end();
    chk("R10 oe low after abort", do_oe, 1'b0);
    write_reg(8'h07, 8'h5A);
    chk("R10 next frame decoded", rg(7), 8'h5A);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1;
    wait_clk(5);
    t_reset();
    t_regwrite();
    t_unimpl();
    t_badaddr();
    t_offset();
    t_init();
    t_packet();
    t_readout();
    t_abort();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule